// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between six active-low external interrupt pins and the interrupt controller. Two of the pins are configurable. A per-input mode bit makes each one either a latched falling-edge request or a level request that follows the pin. The other four pins always latch on falling edges. Every pin passes through a two-flop synchronizer. A falling edge is the synchronized value going from 1 to 0.

Each input has a pending flag that software can set and clear. For each configurable input in edge mode, the CPU pulses an acknowledge when it vectors to that input's service routine, and the latched flag clears. In level mode the pending output is the inverted synchronized pin. A pin that is still low when the routine returns therefore keeps requesting service. The four fixed inputs clear only through a software write. Priority and vectoring are handled elsewhere.

Top module: `ext_irq_cond`

## Requirements
- R1: While reset is asserted, and right after it is released with all pins high, `cfg_pend_o` and `fix_pend_o` are all zero.
- R2: In edge mode (`cfg_mode_i[i]`=1), a falling edge on `cfg_pin_ni[i]` sets `cfg_pend_o[i]`. The flag is visible after the third rising clock edge following the pin change. It stays set after the pin returns high.
- R3: In level mode (`cfg_mode_i[i]`=0), `cfg_pend_o[i]` equals the inverted pin with two cycles of synchronizer latency, and nothing is latched.
- R4: In edge mode, a one-cycle pulse on `vec_ack_i[i]` clears `cfg_pend_o[i]` at the next clock edge.
- R5: In level mode, `vec_ack_i[i]` has no effect: a pin still held low keeps `cfg_pend_o[i]` at 1.
- R6: A cycle with `cfg_wr_i[i]`=1 loads `cfg_wdata_i[i]` into the edge-mode flag at the next edge (1 sets, 0 clears). In level mode the write is ignored.
- R7: When a synchronized falling edge on a configurable input coincides with an acknowledge or a write of 0 to that input, the flag ends up set.
- R8: Fixed input j (`fix_pin_ni[j]`, bit j of `fix_pend_o`) is always edge-sensitive. If its flag is cleared while the pin stays low, the flag stays clear.
- R9: A `fix_wr_i` cycle loads all four fixed flags from `fix_wdata_i`. `vec_ack_i` never changes them. A falling edge that coincides with a write of 0 leaves that flag set.
- R10: While an input is in level mode its latched edge flag is held clear. After a switch back to edge mode the flag reads 0 until a new falling edge occurs.
- R11: A rising edge on any pin never sets a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_pin_ni | input | NUM_CFG | Configurable interrupt pins, active low |
| cfg_mode_i | input | NUM_CFG | Per-input trigger mode: 1 edge, 0 level |
| cfg_wr_i | input | NUM_CFG | Per-bit software write strobe for configurable flags |
| cfg_wdata_i | input | NUM_CFG | Software write data for configurable flags |
| vec_ack_i | input | NUM_CFG | CPU vectored to the routine of configurable input i |
| fix_pin_ni | input | NUM_FIX | Edge-only interrupt pins, active low |
| fix_wr_i | input | 1 | Software write strobe for the fixed-flag register |
| fix_wdata_i | input | NUM_FIX | Software write data for the fixed-flag register |
| cfg_pend_o | output | NUM_CFG | Pending requests of configurable inputs |
| fix_pend_o | output | NUM_FIX | Pending flags of fixed inputs |

## Verification
The hardest cases are the collisions: an acknowledge or a clearing write must land on the same cycle as the internal falling-edge strobe. That strobe sits two register stages behind the pin and cannot be seen at the ports. The bench counts edges from the pin change. It drives the pin low half a cycle before edge k and applies the acknowledge or write for exactly edge k+2, when the strobe is live. The same counting places a level-mode pin that is still low across an acknowledge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;

  localparam int unsigned SYNC_DEPTH = 2;

  // edge set has priority over any clear source
  function automatic logic flag_next(logic cur, logic set_evt, logic wr, logic wdata, logic clr);
    if (set_evt)  return 1'b1;
    if (wr)       return wdata;
    if (clr)      return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_fall_det.sv
module ext_irq_fall_det #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/ext_irq_cfg_chan.sv
module ext_irq_cfg_chan
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] lvl_i,
  input  logic [NUM-1:0] fall_i,
  input  logic [NUM-1:0] mode_i,
  input  logic [NUM-1:0] wr_i,
  input  logic [NUM-1:0] wdata_i,
  input  logic [NUM-1:0] ack_i,
  output logic [NUM-1:0] pend_o
);
  for (genvar i = 0; i < NUM; i++) begin : g_ch
    trig_mode_e mode;
    logic       flag_q, flag_d;

    assign mode = trig_mode_e'(mode_i[i]);

    always_comb begin
      if (mode == TRIG_EDGE) flag_d = flag_next(flag_q, fall_i[i], wr_i[i], wdata_i[i], ack_i[i]);
      else                   flag_d = 1'b0;  // latched flag discarded in level mode
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= flag_d;
    end

    assign pend_o[i] = (mode == TRIG_EDGE) ? flag_q : ~lvl_i[i];
  end
endmodule

// File: rtl/ext_irq_fix_flags.sv
module ext_irq_fix_flags
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] fall_i,
  input  logic           wr_i,
  input  logic [NUM-1:0] wdata_i,
  output logic [NUM-1:0] pend_o
);
  logic [NUM-1:0] flag_q, flag_d;

  for (genvar j = 0; j < NUM; j++) begin : g_bit
    assign flag_d[j] = flag_next(flag_q[j], fall_i[j], wr_i, wdata_i[j], 1'b0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign pend_o = flag_q;
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_CFG = 2,
  parameter int unsigned NUM_FIX = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CFG-1:0] cfg_pin_ni,
  input  logic [NUM_CFG-1:0] cfg_mode_i,
  input  logic [NUM_CFG-1:0] cfg_wr_i,
  input  logic [NUM_CFG-1:0] cfg_wdata_i,
  input  logic [NUM_CFG-1:0] vec_ack_i,
  input  logic [NUM_FIX-1:0] fix_pin_ni,
  input  logic               fix_wr_i,
  input  logic [NUM_FIX-1:0] fix_wdata_i,
  output logic [NUM_CFG-1:0] cfg_pend_o,
  output logic [NUM_FIX-1:0] fix_pend_o
);
  localparam int unsigned NUM_PIN = NUM_CFG + NUM_FIX;

  logic [NUM_PIN-1:0] pin_sync, pin_fall;

  ext_irq_sync #(.WIDTH(NUM_PIN), .STAGES(SYNC_DEPTH)) u_sync (
    .clk_i, .rst_ni, .d_i({fix_pin_ni, cfg_pin_ni}), .q_o(pin_sync)
  );

  ext_irq_fall_det #(.WIDTH(NUM_PIN)) u_fall (
    .clk_i, .rst_ni, .lvl_i(pin_sync), .fall_o(pin_fall)
  );

  ext_irq_cfg_chan #(.NUM(NUM_CFG)) u_cfg (
    .clk_i, .rst_ni,
    .lvl_i  (pin_sync[NUM_CFG-1:0]),
    .fall_i (pin_fall[NUM_CFG-1:0]),
    .mode_i (cfg_mode_i),
    .wr_i   (cfg_wr_i),
    .wdata_i(cfg_wdata_i),
    .ack_i  (vec_ack_i),
    .pend_o (cfg_pend_o)
  );

  ext_irq_fix_flags #(.NUM(NUM_FIX)) u_fix (
    .clk_i, .rst_ni,
    .fall_i (pin_fall[NUM_PIN-1:NUM_CFG]),
    .wr_i   (fix_wr_i),
    .wdata_i(fix_wdata_i),
    .pend_o (fix_pend_o)
  );
endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk #(
  parameter int unsigned NUM_CFG = 2,
  parameter int unsigned NUM_FIX = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_CFG-1:0] cfg_pin_ni,
  input logic [NUM_CFG-1:0] cfg_mode_i,
  input logic [NUM_CFG-1:0] cfg_wr_i,
  input logic [NUM_CFG-1:0] cfg_wdata_i,
  input logic [NUM_CFG-1:0] vec_ack_i,
  input logic               fix_wr_i,
  input logic [NUM_CFG-1:0] cfg_pend_o,
  input logic [NUM_FIX-1:0] fix_pend_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    assert_level_mirror_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q == 2'd3 && !cfg_mode_i[i] && cfg_pin_ni[i] == $past(cfg_pin_ni[i])
       && $past(cfg_pin_ni[i]) == $past(cfg_pin_ni[i], 2))
      |-> cfg_pend_o[i] == !cfg_pin_ni[i]);

    assert_ack_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_q == 2'd3 && cfg_mode_i[i] && vec_ack_i[i] && !cfg_wr_i[i] && cfg_pin_ni[i]
       && $past(cfg_pin_ni[i]) && $past(cfg_pin_ni[i], 2))
      |=> (!cfg_mode_i[i] || !cfg_pend_o[i]));

    assert_sw_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_mode_i[i] && cfg_wr_i[i] && cfg_wdata_i[i]) |=> (!cfg_mode_i[i] || cfg_pend_o[i]));

    assert_edge_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_mode_i[i] && cfg_pend_o[i] && !vec_ack_i[i] && !cfg_wr_i[i])
      |=> (!cfg_mode_i[i] || cfg_pend_o[i]));
  end

  for (genvar j = 0; j < NUM_FIX; j++) begin : g_fix
    assert_fix_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fix_wr_i && fix_pend_o[j]) |=> fix_pend_o[j]);
  end
endmodule

bind ext_irq_cond ext_irq_cond_chk #(.NUM_CFG(NUM_CFG), .NUM_FIX(NUM_FIX)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_pin_ni(cfg_pin_ni), .cfg_mode_i(cfg_mode_i),
  .cfg_wr_i(cfg_wr_i), .cfg_wdata_i(cfg_wdata_i), .vec_ack_i(vec_ack_i),
  .fix_wr_i(fix_wr_i), .cfg_pend_o(cfg_pend_o), .fix_pend_o(fix_pend_o)
);

// File: tb/tb_ext_irq_cond.sv
module tb_ext_irq_cond;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cfg_pin_n = 2'b11, cfg_mode = 2'b00, cfg_wr = '0, cfg_wdata = '0, vec_ack = '0;
  logic [3:0] fix_pin_n = 4'b1111, fix_wdata = '0;
  logic       fix_wr = 1'b0;
  logic [1:0] cfg_pend;
  logic [3:0] fix_pend;
  int         n_cmp = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ext_irq_cond dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_pin_ni(cfg_pin_n), .cfg_mode_i(cfg_mode),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .vec_ack_i(vec_ack),
    .fix_pin_ni(fix_pin_n), .fix_wr_i(fix_wr), .fix_wdata_i(fix_wdata),
    .cfg_pend_o(cfg_pend), .fix_pend_o(fix_pend)
  );

  // {mode, cfg_pin, fix_pin, exp_cfg, exp_fix}
  localparam logic [13:0] VEC [10] = '{
    {2'b11, 2'b11, 4'b1111, 2'b00, 4'b0000},  // R11 idle
    {2'b11, 2'b10, 4'b1110, 2'b01, 4'b0001},  // R2 R8 fall
    {2'b11, 2'b11, 4'b1111, 2'b01, 4'b0001},  // R2 held, R11
    {2'b11, 2'b01, 4'b0111, 2'b11, 4'b1001},  // R2 R8
    {2'b01, 2'b01, 4'b0111, 2'b11, 4'b1001},  // R3 level low
    {2'b01, 2'b11, 4'b1111, 2'b01, 4'b1001},  // R3 follows
    {2'b00, 2'b11, 4'b1111, 2'b00, 4'b1001},  // R10 discard, R3
    {2'b00, 2'b00, 4'b1111, 2'b11, 4'b1001},  // R3
    {2'b11, 2'b00, 4'b1111, 2'b00, 4'b1001},  // R10 no stale flag
    {2'b11, 2'b11, 4'b1111, 2'b00, 4'b1001}   // R11 rising
  };

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(2);
    check("R1 cfg in reset", {2'b0, cfg_pend}, 4'b0000);
    check("R1 fix in reset", fix_pend, 4'b0000);
    rst_n = 1'b1;
    cfg_mode = 2'b11;
    tick(3);
    check("R1 cfg after reset", {2'b0, cfg_pend}, 4'b0000);

    for (int v = 0; v < 10; v++) begin
      cfg_mode  = VEC[v][13:12];
      cfg_pin_n = VEC[v][11:10];
      fix_pin_n = VEC[v][9:6];
      tick(3);
      check($sformatf("R2/R3/R8/R10/R11 vec%0d cfg", v), {2'b0, cfg_pend}, {2'b0, VEC[v][5:4]});
      check($sformatf("R8/R11 vec%0d fix", v), fix_pend, VEC[v][3:0]);
    end

    // R9 write and ack immunity
    fix_wr = 1; fix_wdata = 4'b0000; tick(1); fix_wr = 0;
    check("R9 write 0", fix_pend, 4'b0000);
    fix_wr = 1; fix_wdata = 4'b0101; tick(1); fix_wr = 0;
    check("R9 write 1", fix_pend, 4'b0101);
    vec_ack = 2'b11; tick(1); vec_ack = 0;
    check("R9 ack ignored", fix_pend, 4'b0101);

    // R6 software set/clear, R4 ack clear
    cfg_wr = 2'b01; cfg_wdata = 2'b01; tick(1); cfg_wr = 0;
    check("R6 set", {2'b0, cfg_pend}, 4'b0001);
    cfg_wr = 2'b01; cfg_wdata = 2'b00; tick(1); cfg_wr = 0;
    check("R6 clear", {2'b0, cfg_pend}, 4'b0000);
    cfg_wr = 2'b10; cfg_wdata = 2'b10; tick(1); cfg_wr = 0;
    check("R6 set bit1", {2'b0, cfg_pend}, 4'b0010);
    vec_ack = 2'b10; tick(1); vec_ack = 0;
    check("R4 ack clear", {2'b0, cfg_pend}, 4'b0000);

    // R7 edge vs ack
    cfg_pin_n[0] = 0; tick(2);
    vec_ack = 2'b01; tick(1); vec_ack = 0;
    check("R7 edge beats ack", {3'b0, cfg_pend[0]}, 4'b0001);
    cfg_pin_n[0] = 1; tick(3);
    // R7 edge vs write 0
    cfg_pin_n[1] = 0; tick(2);
    cfg_wr = 2'b10; cfg_wdata = 2'b00; tick(1); cfg_wr = 0;
    check("R7 edge beats write0", {3'b0, cfg_pend[1]}, 4'b0001);
    cfg_pin_n[1] = 1; tick(3);

    // R9 edge vs write 0
    fix_pin_n[3] = 0; tick(2);
    fix_wr = 1; fix_wdata = 4'b0000; tick(1); fix_wr = 0;
    check("R9 edge beats write0", fix_pend, 4'b1000);
    fix_pin_n[3] = 1; tick(3);

    // R8 held low, no re-set
    fix_pin_n[2] = 0; tick(3);
    check("R8 set", fix_pend, 4'b1100);
    fix_wr = 1; fix_wdata = 4'b0000; tick(1); fix_wr = 0;
    tick(5);
    check("R8 stays clear while low", fix_pend, 4'b0000);
    fix_pin_n[2] = 1; tick(3);

    // R5 level ack no effect
    cfg_mode = 2'b10; cfg_pin_n[0] = 0; tick(3);
    check("R5 level pending", {3'b0, cfg_pend[0]}, 4'b0001);
    vec_ack = 2'b01; tick(1); vec_ack = 0; tick(2);
    check("R5 still pending after ack", {3'b0, cfg_pend[0]}, 4'b0001);

    // R6 writes ignored in level mode
    cfg_mode = 2'b00; tick(3);
    check("R3 level high", {3'b0, cfg_pend[1]}, 4'b0000);
    cfg_wr = 2'b11; cfg_wdata = 2'b10; tick(1); cfg_wr = 0; tick(1);
    check("R6 level write ignored", {2'b0, cfg_pend}, 4'b0001);

    // R1 reset with flags set
    cfg_pin_n = 2'b11; cfg_mode = 2'b11; tick(3);
    cfg_wr = 2'b11; cfg_wdata = 2'b11; fix_wr = 1; fix_wdata = 4'b1111; tick(1);
    cfg_wr = 0; fix_wr = 0;
    check("R6 both set", {2'b0, cfg_pend}, 4'b0011);
    rst_n = 0; tick(1);
    check("R1 cfg mid reset", {2'b0, cfg_pend}, 4'b0000);
    check("R1 fix mid reset", fix_pend, 4'b0000);
    rst_n = 1; tick(3);
    check("R1 after re-reset", {cfg_pend, 2'b0} | {2'b0, fix_pend[1:0]}, 4'b0000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule